// File: doc/BRIEF.md
# Delay-Slot Branch and Next-PC Unit

This block chooses where instruction fetch goes next in a five-stage, 32-bit pipelined processor whose branches and jumps have one delay slot. It owns the program counter register and the +4 incrementer of the fetch stage. Control transfers are settled while the transfer instruction sits in decode. The unit takes that instruction's decoded control flags, its sign-extended immediate, its 26-bit jump field and the two register read values. A dedicated equality comparator on the two read buses decides conditional branches, so no ALU flag is needed.

By the time decode sees a branch, fetch already holds the delay-slot instruction. That instruction always runs and nothing is squashed. All targets are therefore built from the PC currently in fetch, and the fall-through address is the fetch PC+4. Link instructions need a return address that skips the delay slot. It is made by adding 4 to the PC+4 value that travelled with the instruction through the fetch/decode register.

Top module: `dslot_pc_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `fetch_pc` to 0 at the next rising clock edge.
- R2: While `ld_en` is low and `rst` is low, `fetch_pc` keeps its value across clock edges. While `ld_en` is high, `fetch_pc` takes the value `next_pc` had before the edge.
- R3: `fetch_pc4` always equals `fetch_pc + 4`. With no control flag raised, `next_pc` equals `fetch_pc + 4`.
- R4: With `dec_beq` high, the branch is taken when `rs_val == rt_val`. A taken branch makes `next_pc = fetch_pc + (dec_imm << 2)`. A branch that is not taken gives `fetch_pc + 4`.
- R5: With `dec_bne` high, the branch is taken when `rs_val != rt_val`. The same target and fall-through rules as R4 apply.
- R6: With `dec_jmp` high, `next_pc = {fetch_pc[31:28], dec_jfield, 2'b00}`.
- R7: With `dec_jreg` high, `next_pc = {rs_val[31:2], 2'b00}`. The two low bits of the register value are dropped.
- R8: Priority order is `dec_jreg`, then `dec_jmp`, then the branches. When both branch flags are high, the branch is taken if either condition holds.
- R9: `link_addr` always equals `dec_pc4 + 4`. `link_wr` is high exactly when `dec_link` is high together with `dec_jmp` or `dec_jreg`.
- R10: The two low bits of `fetch_pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | PC load enable |
| dec_beq | input | 1 | Decode holds branch-if-equal |
| dec_bne | input | 1 | Decode holds branch-if-not-equal |
| dec_jmp | input | 1 | Decode holds an absolute (field) jump |
| dec_jreg | input | 1 | Decode holds a register jump |
| dec_link | input | 1 | Decode jump also writes a return address |
| dec_imm | input | 32 | Sign-extended immediate of the decode instruction |
| dec_jfield | input | 26 | Jump field of the decode instruction |
| dec_pc4 | input | 32 | PC+4 latched beside the decode instruction |
| rs_val | input | 32 | First register read value |
| rt_val | input | 32 | Second register read value |
| fetch_pc | output | 32 | Current fetch address |
| fetch_pc4 | output | 32 | Fetch address plus 4, for the fetch/decode register |
| next_pc | output | 32 | Address loaded at the next enabled edge |
| link_addr | output | 32 | Return address (skips the delay slot) |
| link_wr | output | 1 | Return address is to be written |

## Verification
The bench uses negative and positive branch offsets and checks that targets come from the fetch PC. A design that used the fetch PC+4 would land one instruction too far. It raises a jump with the fetch PC in the top 16th of the address space, so a design that dropped or zeroed the upper four PC bits produces a low address. It loads odd register values into a register jump, and a design that kept the low bits would leave the PC misaligned. It also raises several control flags at once: a wrong priority picks the wrong target, and a link value taken from the fetch PC instead of the latched decode PC+4 differs from the expected return address.

// File: rtl/dslot_pc_pkg.sv
package dslot_pc_pkg;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_BR   = 2'd1,
        SEL_JMP  = 2'd2,
        SEL_JREG = 2'd3
    } pc_sel_e;

    localparam int unsigned WORD_SHIFT = 2;
    localparam int unsigned WORD_BYTES = 1 << WORD_SHIFT;

endpackage

// File: rtl/dslot_eq_cmp.sv
module dslot_eq_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] diff;

    always_comb begin
        diff = a ^ b;
        eq   = ~|diff;
    end
endmodule

// File: rtl/dslot_target_gen.sv
module dslot_target_gen
    import dslot_pc_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned JW   = 26
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm,
    input  logic [JW-1:0]   jfield,
    input  logic [XLEN-1:0] rs,
    output logic [XLEN-1:0] br_tgt,
    output logic [XLEN-1:0] jmp_tgt,
    output logic [XLEN-1:0] jreg_tgt
);
    localparam int unsigned UPPER = XLEN - JW - WORD_SHIFT;

    always_comb begin
        // targets are relative to the delay-slot address held in fetch
        br_tgt   = pc + (imm << WORD_SHIFT);
        jmp_tgt  = {pc[XLEN-1 -: UPPER], jfield, {WORD_SHIFT{1'b0}}};
        jreg_tgt = {rs[XLEN-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/dslot_pc_sel.sv
module dslot_pc_sel
    import dslot_pc_pkg::*;
(
    input  logic    beq,
    input  logic    bne,
    input  logic    jmp,
    input  logic    jreg,
    input  logic    eq,
    output pc_sel_e sel
);
    logic br_taken;

    always_comb begin
        br_taken = (beq && eq) || (bne && !eq);
        if (jreg)          sel = SEL_JREG;
        else if (jmp)      sel = SEL_JMP;
        else if (br_taken) sel = SEL_BR;
        else               sel = SEL_SEQ;
    end
endmodule

// File: rtl/dslot_pc_unit.sv
module dslot_pc_unit
    import dslot_pc_pkg::*;
#(
    parameter int unsigned   XLEN     = 32,
    parameter int unsigned   JW       = 26,
    parameter logic [31:0]   RESET_PC = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic            dec_beq,
    input  logic            dec_bne,
    input  logic            dec_jmp,
    input  logic            dec_jreg,
    input  logic            dec_link,
    input  logic [XLEN-1:0] dec_imm,
    input  logic [JW-1:0]   dec_jfield,
    input  logic [XLEN-1:0] dec_pc4,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] fetch_pc,
    output logic [XLEN-1:0] fetch_pc4,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] link_addr,
    output logic            link_wr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

    pc_state_t       st_d, st_q;
    logic            regs_eq;
    pc_sel_e         sel;
    logic [XLEN-1:0] br_tgt, jmp_tgt, jreg_tgt;
    logic [XLEN-1:0] seq_pc;

    dslot_eq_cmp #(.W(XLEN)) u_cmp (
        .a  (rs_val),
        .b  (rt_val),
        .eq (regs_eq)
    );

    dslot_target_gen #(.XLEN(XLEN), .JW(JW)) u_tgt (
        .pc       (st_q.pc),
        .imm      (dec_imm),
        .jfield   (dec_jfield),
        .rs       (rs_val),
        .br_tgt   (br_tgt),
        .jmp_tgt  (jmp_tgt),
        .jreg_tgt (jreg_tgt)
    );

    dslot_pc_sel u_sel (
        .beq  (dec_beq),
        .bne  (dec_bne),
        .jmp  (dec_jmp),
        .jreg (dec_jreg),
        .eq   (regs_eq),
        .sel  (sel)
    );

    always_comb begin
        seq_pc = st_q.pc + STEP;
        unique case (sel)
            SEL_JREG: next_pc = jreg_tgt;
            SEL_JMP:  next_pc = jmp_tgt;
            SEL_BR:   next_pc = br_tgt;
            default:  next_pc = seq_pc;
        endcase
        st_d = st_q;
        if (ld_en) st_d.pc = next_pc;
        fetch_pc  = st_q.pc;
        fetch_pc4 = seq_pc;
        // return address skips the delay slot: latched PC+4 plus one word
        link_addr = dec_pc4 + STEP;
        link_wr   = dec_link && (dec_jmp || dec_jreg);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: RESET_PC[XLEN-1:0]};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dslot_pc_unit_chk.sv
module dslot_pc_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            ld_en,
    input logic            dec_jmp,
    input logic            dec_jreg,
    input logic            dec_link,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] fetch_pc,
    input logic [XLEN-1:0] fetch_pc4,
    input logic [XLEN-1:0] next_pc,
    input logic            link_wr
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> fetch_pc == '0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !$past(rst)) |=> fetch_pc == $past(fetch_pc));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> fetch_pc == $past(next_pc));

    assert_incr_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_pc4 == fetch_pc + XLEN'(4));

    assert_jreg_first_R8: assert property (@(posedge clk) disable iff (rst)
        dec_jreg |-> next_pc == {rs_val[XLEN-1:2], 2'b00});

    assert_no_link_R9: assert property (@(posedge clk) disable iff (rst)
        (!dec_jmp && !dec_jreg) |-> !link_wr);

    assert_link_R9: assert property (@(posedge clk) disable iff (rst)
        (dec_link && (dec_jmp || dec_jreg)) |-> link_wr);

    assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_pc[1:0] == 2'b00);
endmodule

bind dslot_pc_unit dslot_pc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .dec_jmp   (dec_jmp),
    .dec_jreg  (dec_jreg),
    .dec_link  (dec_link),
    .rs_val    (rs_val),
    .fetch_pc  (fetch_pc),
    .fetch_pc4 (fetch_pc4),
    .next_pc   (next_pc),
    .link_wr   (link_wr)
);

// File: tb/tb_dslot_pc_unit.sv
module tb_dslot_pc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        dec_beq = 1'b0, dec_bne = 1'b0, dec_jmp = 1'b0, dec_jreg = 1'b0, dec_link = 1'b0;
    logic [31:0] dec_imm = '0, dec_pc4 = '0, rs_val = '0, rt_val = '0;
    logic [25:0] dec_jfield = '0;
    logic [31:0] fetch_pc, fetch_pc4, next_pc, link_addr;
    logic        link_wr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dslot_pc_unit dut (
        .clk(clk), .rst(rst), .ld_en(ld_en),
        .dec_beq(dec_beq), .dec_bne(dec_bne), .dec_jmp(dec_jmp),
        .dec_jreg(dec_jreg), .dec_link(dec_link),
        .dec_imm(dec_imm), .dec_jfield(dec_jfield), .dec_pc4(dec_pc4),
        .rs_val(rs_val), .rt_val(rt_val),
        .fetch_pc(fetch_pc), .fetch_pc4(fetch_pc4), .next_pc(next_pc),
        .link_addr(link_addr), .link_wr(link_wr)
    );

    typedef struct {
        string       tag;
        logic [31:0] pc;
        logic [31:0] pc4;
        logic [31:0] npc;
        logic [31:0] link;
        logic        lwr;
    } exp_t;

    exp_t        sbq[$];
    event        chk_ev;
    logic [31:0] model_pc = '0;

    task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check32(e.tag, "fetch_pc", fetch_pc, e.pc);
                check32(e.tag, "fetch_pc4", fetch_pc4, e.pc4);
                check32(e.tag, "next_pc", next_pc, e.npc);
                check32(e.tag, "link_addr", link_addr, e.link);
                check32(e.tag, "link_wr", {31'b0, link_wr}, {31'b0, e.lwr});
            end
        end
    end

    // driver: applies one decode cycle and pushes what the outputs must be
    task automatic drive(input string tag, input logic ld,
                         input logic beq, input logic bne, input logic jmp,
                         input logic jreg, input logic lnk,
                         input logic [31:0] imm, input logic [25:0] jf,
                         input logic [31:0] pc4l, input logic [31:0] rs, input logic [31:0] rt);
        exp_t e;
        logic taken;
        @(negedge clk);
        ld_en = ld; dec_beq = beq; dec_bne = bne; dec_jmp = jmp; dec_jreg = jreg;
        dec_link = lnk; dec_imm = imm; dec_jfield = jf; dec_pc4 = pc4l;
        rs_val = rs; rt_val = rt;
        taken = (beq && rs == rt) || (bne && rs != rt);
        e.tag  = tag;
        e.pc   = model_pc;
        e.pc4  = model_pc + 32'd4;
        if (jreg)       e.npc = {rs[31:2], 2'b00};
        else if (jmp)   e.npc = {model_pc[31:28], jf, 2'b00};
        else if (taken) e.npc = model_pc + {imm[29:0], 2'b00};
        else            e.npc = model_pc + 32'd4;
        e.link = pc4l + 32'd4;
        e.lwr  = lnk && (jmp || jreg);
        sbq.push_back(e);
        #1;
        ->chk_ev;
        @(posedge clk);
        if (ld) model_pc = e.npc;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check32("R1", "fetch_pc after reset", fetch_pc, 32'h0);
        rst = 1'b0;
        model_pc = '0;
        // R3 sequential
        drive("R3", 1, 0,0,0,0,0, 32'h0, '0, 32'h10, 32'h1, 32'h2);
        drive("R3", 1, 0,0,0,0,0, 32'h0, '0, 32'h10, 32'h1, 32'h2);
        // R2 hold with a jump present: PC must not move
        drive("R2", 0, 0,0,1,0,0, 32'h0, 26'h12345, 32'h10, 32'h0, 32'h0);
        drive("R2", 0, 0,0,0,0,0, 32'h0, '0, 32'h10, 32'h0, 32'h0);
        drive("R2", 1, 0,0,0,0,0, 32'h0, '0, 32'h10, 32'h0, 32'h0);
        // R4 beq taken forward, not taken
        drive("R4", 1, 1,0,0,0,0, 32'h0000_0010, '0, 32'h0, 32'hAB, 32'hAB);
        drive("R4", 1, 1,0,0,0,0, 32'h0000_0010, '0, 32'h0, 32'hAB, 32'hAC);
        // R4 beq taken backward
        drive("R4", 1, 1,0,0,0,0, 32'hFFFF_FFF8, '0, 32'h0, 32'h5, 32'h5);
        // R5 bne taken and not taken
        drive("R5", 1, 0,1,0,0,0, 32'h0000_0004, '0, 32'h0, 32'h1, 32'h2);
        drive("R5", 1, 0,1,0,0,0, 32'h0000_0004, '0, 32'h0, 32'h7, 32'h7);
        // R7 register jump with odd low bits, into top of address space
        drive("R7", 1, 0,0,0,1,1, 32'h0, '0, 32'h0000_0044, 32'hF000_0103, 32'h0);
        // R6 field jump keeps upper PC bits
        drive("R6", 1, 0,0,1,0,0, 32'h0, 26'h2AB_CDEF, 32'h0, 32'h0, 32'h0);
        drive("R6", 1, 0,0,1,0,1, 32'h0, 26'h000_0010, 32'hF000_0100, 32'h0, 32'h0);
        // R8 priority: jreg over jmp over branch
        drive("R8", 1, 1,0,1,1,0, 32'h40, 26'h3FF_FFFF, 32'h0, 32'h0000_2000, 32'h0000_2000);
        drive("R8", 1, 1,0,1,0,0, 32'h40, 26'h000_0800, 32'h0, 32'h9, 32'h9);
        drive("R8", 1, 1,1,0,0,0, 32'h8, '0, 32'h0, 32'h9, 32'h3);
        // R9 link flag needs a jump
        drive("R9", 1, 1,0,0,0,1, 32'h4, '0, 32'h1234_5678, 32'h1, 32'h1);
        drive("R9", 1, 0,0,0,1,1, 32'h0, '0, 32'hFFFF_FFFC, 32'h0000_0300, 32'h0);
        // R10 alignment after several updates
        @(negedge clk);
        check32("R10", "fetch_pc low bits", {30'b0, fetch_pc[1:0]}, 32'h0);
        // R1 reset from nonzero PC
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check32("R1", "fetch_pc after late reset", fetch_pc, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule